// File: doc/BRIEF.md
# Display Controller Register Unlock Block

This block is the memory-mapped register front end of a combined memory and display controller. A host reaches it through a plain single-cycle bus: `wr_en` writes a full 32-bit word into the register that the upper offset bits select, and `rd_en` returns a sub-word picked out with big-endian byte lanes. It holds a fixed CPU identification word, DRAM timing and refresh words, eight memory bank base addresses, the frame buffer base and row pitch, two configuration words, a monitor-sense code and a system bus configuration field.

Video output is not switched on by a simple enable bit. Software must write three fixed values in a row to a dedicated frame-buffer reset register. Whether the last of them turns the display on or only blanks it depends on a bit in configuration word 1. A separate code switches running video off. The same register also arms a flag that, on a small VRAM fitted with the full-banks option, tells the VRAM path to force address bit 2 high on reads.

Three interrupt sources (cursor line, animation line, vertical blank) set bits in a status register. A mask register gates them onto one interrupt line. Reading a dedicated per-source register returns 0 and clears that source's status bit.

Top module: `dispctl_regblk`

## Requirements
- R1: After reset every register reads 0, except the CPU identification word (default 32'h5A01_0210) and the monitor-sense register, which reads 7. `video_on`, `video_blank`, `half_access` and `irq` are 0.
- R2: The register index is the offset divided by 16, carried on `slot_addr`. Slots: 0 CPU id, 1 DRAM timing, 2 refresh, 3 cache config, 4 to 11 bank bases 0 to 7, 12 frame buffer base, 13 row pitch, 14 config 1, 15 config 2, 16 monitor sense, 17 frame-buffer reset, 18 interrupt status, 19 interrupt mask, 20/21/22 clear cursor/animation/vblank, 23 bus config. A write to one slot changes no other slot.
- R3: A read of N bytes (`rd_size` 1, 2 or 4) at byte lane L returns the 32-bit value V placed twice into 64 bits, {V,V}, shifted right by (8-L-N)*8 and masked to N bytes. Lane 0 is the most significant byte.
- R4: Writing 3, then 2, then 0 to slot 17 with config 1 bit 0 set raises `video_on` and clears `video_blank` in the cycle after the third write.
- R5: The same sequence with config 1 bit 0 clear sets `video_blank` and leaves `video_on` unchanged.
- R6: Writing 7 to slot 17 while `video_on` is 1 clears `video_on` and restarts the sequence. Any write to slot 17 that is not the next expected value restarts the sequence, and that value is then not counted as a first step.
- R7: Every write to slot 17 sets `half_access` to 1 exactly when `vram_small` is 1, config 1 bit 1 (full banks) is 1 and the written value is 6, and to 0 otherwise. Writes to other slots leave it unchanged.
- R8: A write to slot 16 keeps only bits 2:0. A read returns those bits XOR 7.
- R9: A write to slot 13 stores the value with bits 2:0 cleared, and this drives `row_pitch`. A write to slot 12 also drives `fb_offset` with the low 22 bits.
- R10: Slot 3 reads as 0 and ignores writes. A write to slot 23 stores only bits 2:0, and the rest read as 0.
- R11: A pulse on `src_evt[k]` (0 cursor, 1 animation, 2 vblank) sets status bit k (slot 18). Slot 19 holds the mask in bits 2:0. `irq` is 1 exactly when some status bit and its mask bit are both 1.
- R12: A read of slot 20+k returns 0 and clears status bit k. A `src_evt[k]` pulse in the same cycle wins, and the bit stays 1.
- R13: Slots 24 to 255 and the frame-buffer reset slot 17 read 0. Writes to slots 24 to 255 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vram_small | input | 1 | Strap: 1 MB VRAM fitted |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clear-on-read side effects) |
| slot_addr | input | ADDR_W-4 | Offset bits above bit 3: register index |
| byte_lane | input | 2 | Offset bits 1:0 of a read |
| rd_size | input | 3 | Read size in bytes (1, 2 or 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Formatted read data, combinational |
| src_evt | input | NSRC | Interrupt source event pulses |
| irq | output | 1 | Masked interrupt line |
| video_on | output | 1 | Display running |
| video_blank | output | 1 | Display blanked |
| half_access | output | 1 | Force VRAM read address bit 2 |
| fb_offset | output | FB_OFS_W | VRAM offset of the frame buffer |
| row_pitch | output | 32 | Row pitch, 8-byte aligned |

## Verification
The bench goes after the unlock sequence's restart rule: a broken sequence such as 3,5,2,0, a kill code written while video is off, and a clean sequence right after a break. A design that kept a partial count, or that counted the breaking value as a fresh first step, would switch video on there. It also probes sub-word reads whose lanes wrap past the end of the word (lane 3, size 2). A little-endian or non-wrapping formatter returns swapped or zero-filled bytes there. Further cases are a clear-on-read that lands in the same cycle as a new event, which a design giving the clear priority would lose, and the half-access flag once its qualifying conditions drop away, which a design that latched the flag would leave set.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;
  localparam int NUM_BANKS = 8;

  localparam logic [7:0] RI_CPU_ID   = 8'd0;
  localparam logic [7:0] RI_DRAM_TIM = 8'd1;
  localparam logic [7:0] RI_REFRESH  = 8'd2;
  localparam logic [7:0] RI_CACHE    = 8'd3;
  localparam logic [7:0] RI_BANK0    = 8'd4;
  localparam logic [7:0] RI_FB_BASE  = 8'd12;
  localparam logic [7:0] RI_ROW      = 8'd13;
  localparam logic [7:0] RI_CFG1     = 8'd14;
  localparam logic [7:0] RI_CFG2     = 8'd15;
  localparam logic [7:0] RI_SENSE    = 8'd16;
  localparam logic [7:0] RI_FB_RESET = 8'd17;
  localparam logic [7:0] RI_INT_STAT = 8'd18;
  localparam logic [7:0] RI_INT_MASK = 8'd19;
  localparam logic [7:0] RI_CLR_BASE = 8'd20;
  localparam logic [7:0] RI_BUSCFG   = 8'd23;

  localparam int CFG1_VID_EN     = 0;
  localparam int CFG1_FULL_BANKS = 1;

  localparam logic [31:0] UNLK_STEP0 = 32'd3;
  localparam logic [31:0] UNLK_STEP1 = 32'd2;
  localparam logic [31:0] UNLK_STEP2 = 32'd0;
  localparam logic [31:0] KILL_CODE  = 32'd7;
  localparam logic [31:0] HALF_CODE  = 32'd6;
endpackage

// File: rtl/dispctl_unlock.sv
module dispctl_unlock
  import dispctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stb,
  input  logic [31:0] wval,
  input  logic        vid_en_cfg,
  input  logic        half_bank,
  output logic        video_on,
  output logic        video_blank,
  output logic        half_access
);
  logic [1:0]  step_q, step_d;
  logic        on_q, on_d, blank_q, blank_d, half_q, half_d;
  logic [31:0] expect_code;

  always_comb begin
    case (step_q)
      2'd0:    expect_code = UNLK_STEP0;
      2'd1:    expect_code = UNLK_STEP1;
      default: expect_code = UNLK_STEP2;
    endcase
  end

  always_comb begin
    step_d  = step_q;
    on_d    = on_q;
    blank_d = blank_q;
    half_d  = half_q;
    if (wr_stb) begin
      half_d = half_bank && (wval == HALF_CODE);
      if (wval == KILL_CODE && on_q) begin
        on_d   = 1'b0;
        step_d = 2'd0;
      end else if (wval == expect_code) begin
        if (step_q == 2'd2) begin
          step_d = 2'd0;
          if (vid_en_cfg) begin
            on_d    = 1'b1;
            blank_d = 1'b0;
          end else begin
            blank_d = 1'b1;
          end
        end else begin
          step_d = step_q + 2'd1;
        end
      end else begin
        step_d = 2'd0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= 2'd0;
      on_q    <= 1'b0;
      blank_q <= 1'b0;
      half_q  <= 1'b0;
    end else if (wr_stb) begin
      step_q  <= step_d;
      on_q    <= on_d;
      blank_q <= blank_d;
      half_q  <= half_d;
    end
  end

  assign video_on    = on_q;
  assign video_blank = blank_q;
  assign half_access = half_q;
endmodule

// File: rtl/dispctl_irq.sv
module dispctl_irq #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic [NSRC-1:0] clr_stb,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  output logic [NSRC-1:0] status,
  output logic [NSRC-1:0] mask,
  output logic            irq
);
  logic [NSRC-1:0] stat_q, stat_d, mask_q, mask_d;

  always_comb begin
    stat_d = (stat_q & ~clr_stb) | src_evt;
    mask_d = mask_we ? mask_wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (mask_we) mask_q <= mask_d;
    end
  end

  assign status = stat_q;
  assign mask   = mask_q;
  assign irq    = |(stat_q & mask_q);
endmodule

// File: rtl/dispctl_rdfmt.sv
module dispctl_rdfmt (
  input  logic [31:0] val,
  input  logic [1:0]  lane,
  input  logic [2:0]  size,
  output logic [31:0] dout
);
  logic [63:0] dup;
  logic [63:0] shifted;
  logic [3:0]  sh_bytes;

  always_comb begin
    dup      = {val, val};
    sh_bytes = 4'd8 - {2'b00, lane} - {1'b0, size};
    shifted  = dup >> {sh_bytes, 3'b000};
  end

  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign dout[8*b +: 8] = (size > 3'(b)) ? shifted[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/dispctl_regblk.sv
module dispctl_regblk
  import dispctl_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          NSRC     = 3,
  parameter int          FB_OFS_W = 22,
  parameter logic [31:0] CPU_ID   = 32'h5A01_0210
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vram_small,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:4]   slot_addr,
  input  logic [1:0]          byte_lane,
  input  logic [2:0]          rd_size,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [NSRC-1:0]     src_evt,
  output logic                irq,
  output logic                video_on,
  output logic                video_blank,
  output logic                half_access,
  output logic [FB_OFS_W-1:0] fb_offset,
  output logic [31:0]         row_pitch
);
  localparam int IDX_W = ADDR_W - 4;

  logic [1:0]       rst_q;
  logic             rst_int_n;
  logic [IDX_W-1:0] idx;
  logic [7:0]       idx8;

  logic [31:0] dram_tim_q, refresh_q, fb_base_q, row_q, cfg1_q, cfg2_q;
  logic [31:0] bank_q [NUM_BANKS];
  logic [2:0]  sense_q, buscfg_q;
  logic [NSRC-1:0] int_status, int_mask, clr_stb;
  logic        full_banks;
  logic [31:0] rd_val;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  assign idx  = slot_addr;
  assign idx8 = 8'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_tim_q <= '0;
      refresh_q  <= '0;
      fb_base_q  <= '0;
      row_q      <= '0;
      cfg1_q     <= '0;
      cfg2_q     <= '0;
      sense_q    <= '0;
      buscfg_q   <= '0;
    end else if (!rst_int_n) begin
      dram_tim_q <= '0;
      refresh_q  <= '0;
      fb_base_q  <= '0;
      row_q      <= '0;
      cfg1_q     <= '0;
      cfg2_q     <= '0;
      sense_q    <= '0;
      buscfg_q   <= '0;
    end else if (wr_en) begin
      if (idx8 == RI_DRAM_TIM) dram_tim_q <= wdata;
      if (idx8 == RI_REFRESH)  refresh_q  <= wdata;
      if (idx8 == RI_FB_BASE)  fb_base_q  <= wdata;
      if (idx8 == RI_ROW)      row_q      <= {wdata[31:3], 3'b000};
      if (idx8 == RI_CFG1)     cfg1_q     <= wdata;
      if (idx8 == RI_CFG2)     cfg2_q     <= wdata;
      if (idx8 == RI_SENSE)    sense_q    <= wdata[2:0];
      if (idx8 == RI_BUSCFG)   buscfg_q   <= wdata[2:0];
    end
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en && (idx8 == RI_BANK0 + 8'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bank_q[i] <= '0;
      else if (!rst_int_n) bank_q[i] <= '0;
      else if (bank_we)   bank_q[i] <= wdata;
    end
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_clr
    assign clr_stb[k] = rd_en && (idx8 == RI_CLR_BASE + 8'(k));
  end

  assign full_banks = cfg1_q[CFG1_FULL_BANKS];

  dispctl_unlock u_unlk (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_stb      (wr_en && idx8 == RI_FB_RESET),
    .wval        (wdata),
    .vid_en_cfg  (cfg1_q[CFG1_VID_EN]),
    .half_bank   (vram_small && full_banks),
    .video_on    (video_on),
    .video_blank (video_blank),
    .half_access (half_access)
  );

  dispctl_irq #(.NSRC(NSRC)) u_irq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .src_evt    (src_evt),
    .clr_stb    (clr_stb),
    .mask_we    (wr_en && idx8 == RI_INT_MASK),
    .mask_wdata (wdata[NSRC-1:0]),
    .status     (int_status),
    .mask       (int_mask),
    .irq        (irq)
  );

  always_comb begin
    rd_val = '0;
    if (idx8 >= RI_BANK0 && idx8 < RI_BANK0 + 8'(NUM_BANKS)) begin
      for (int i = 0; i < NUM_BANKS; i++)
        if (idx8 == RI_BANK0 + 8'(i)) rd_val = bank_q[i];
    end else begin
      case (idx8)
        RI_CPU_ID:   rd_val = CPU_ID;
        RI_DRAM_TIM: rd_val = dram_tim_q;
        RI_REFRESH:  rd_val = refresh_q;
        RI_FB_BASE:  rd_val = fb_base_q;
        RI_ROW:      rd_val = row_q;
        RI_CFG1:     rd_val = cfg1_q;
        RI_CFG2:     rd_val = cfg2_q;
        RI_SENSE:    rd_val = {29'd0, sense_q ^ 3'b111};
        RI_INT_STAT: rd_val = 32'(int_status);
        RI_INT_MASK: rd_val = 32'(int_mask);
        RI_BUSCFG:   rd_val = {29'd0, buscfg_q};
        default:     rd_val = '0;
      endcase
    end
  end

  dispctl_rdfmt u_fmt (
    .val  (rd_val),
    .lane (byte_lane),
    .size (rd_size),
    .dout (rdata)
  );

  assign fb_offset = fb_base_q[FB_OFS_W-1:0];
  assign row_pitch = row_q;
endmodule

// File: rtl/dispctl_regblk_chk.sv
module dispctl_regblk_chk
  import dispctl_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NSRC     = 3,
  parameter int FB_OFS_W = 22
) (
  input logic                clk,
  input logic                rst_n,
  input logic                vram_small,
  input logic                full_banks,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:4]   slot_addr,
  input logic [31:0]         wdata,
  input logic [31:0]         rdata,
  input logic [NSRC-1:0]     src_evt,
  input logic [NSRC-1:0]     int_status,
  input logic                video_on,
  input logic                half_access,
  input logic [FB_OFS_W-1:0] fb_offset,
  input logic [31:0]         row_pitch
);
  logic [7:0] s8;
  assign s8 = 8'(slot_addr);

  // R6
  kill_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && s8 == RI_FB_RESET && wdata == KILL_CODE && video_on) |=> !video_on);

  // R7
  half_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && s8 == RI_FB_RESET) |=>
      (half_access == $past(vram_small && full_banks && wdata == HALF_CODE)));

  // R9
  row_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && s8 == RI_ROW) |=> (row_pitch == {$past(wdata[31:3]), 3'b000}));

  // R11
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((int_status & $past(src_evt)) == $past(src_evt)));

  // R12
  clr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && s8 >= RI_CLR_BASE && s8 < RI_CLR_BASE + 8'(NSRC)) |-> (rdata == 32'd0));

  // R13
  unknown_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && s8 > RI_BUSCFG && src_evt == '0) |=>
      ($stable(video_on) && $stable(int_status) && $stable(fb_offset) && $stable(half_access)));
endmodule

bind dispctl_regblk dispctl_regblk_chk #(
  .ADDR_W(ADDR_W), .NSRC(NSRC), .FB_OFS_W(FB_OFS_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .vram_small (vram_small),
  .full_banks (full_banks),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .slot_addr  (slot_addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .src_evt    (src_evt),
  .int_status (int_status),
  .video_on   (video_on),
  .half_access(half_access),
  .fb_offset  (fb_offset),
  .row_pitch  (row_pitch)
);

// File: tb/dispctl_regblk_tb.sv
`timescale 1ns/1ps
module dispctl_regblk_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vram_small = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:4] slot_addr = '0;
  logic [1:0]  byte_lane = '0;
  logic [2:0]  rd_size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  src_evt = '0;
  logic        irq, video_on, video_blank, half_access;
  logic [21:0] fb_offset;
  logic [31:0] row_pitch;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dispctl_regblk u_dut (
    .clk(clk), .rst_n(rst_n), .vram_small(vram_small), .wr_en(wr_en), .rd_en(rd_en),
    .slot_addr(slot_addr), .byte_lane(byte_lane), .rd_size(rd_size), .wdata(wdata),
    .rdata(rdata), .src_evt(src_evt), .irq(irq), .video_on(video_on),
    .video_blank(video_blank), .half_access(half_access), .fb_offset(fb_offset),
    .row_pitch(row_pitch)
  );

  // ---------------- behavioural reference model ----------------
  localparam logic [31:0] CPU_ID_EXP = 32'h5A01_0210;
  logic [31:0] m_dram, m_ref, m_fb, m_row, m_c1, m_c2;
  logic [31:0] m_bank [8];
  logic [2:0]  m_sense, m_bus, m_stat, m_mask;
  int          m_step;
  bit          m_on, m_blank, m_half;

  function automatic logic [31:0] mval(int i);
    if (i >= 4 && i <= 11) return m_bank[i-4];
    case (i)
      0:  return CPU_ID_EXP;
      1:  return m_dram;
      2:  return m_ref;
      12: return m_fb;
      13: return m_row;
      14: return m_c1;
      15: return m_c2;
      16: return {29'd0, m_sense ^ 3'd7};
      18: return {29'd0, m_stat};
      19: return {29'd0, m_mask};
      23: return {29'd0, m_bus};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] fmt(logic [31:0] v, int lane, int sz);
    logic [63:0] d = {v, v};
    logic [63:0] r;
    if (sz == 0) return 32'd0;
    r = d >> ((8 - lane - sz) * 8);
    if (sz >= 4) return r[31:0];
    return r[31:0] & ((32'd1 << (sz * 8)) - 32'd1);
  endfunction

  function automatic string tag_of(int i);
    if (i == 0) return "R1";
    if (i >= 4 && i <= 11) return "R2";
    if (i == 3 || i == 23) return "R10";
    if (i == 16) return "R8";
    if (i == 12 || i == 13) return "R9";
    if (i == 18 || i == 19) return "R11";
    if (i >= 20 && i <= 22) return "R12";
    if (i == 17 || i > 23) return "R13";
    return "R3";
  endfunction

  task automatic model_reset();
    m_dram = 0; m_ref = 0; m_fb = 0; m_row = 0; m_c1 = 0; m_c2 = 0;
    foreach (m_bank[i]) m_bank[i] = 0;
    m_sense = 0; m_bus = 0; m_stat = 0; m_mask = 0;
    m_step = 0; m_on = 0; m_blank = 0; m_half = 0;
  endtask

  task automatic model_step();
    int i = int'(slot_addr);
    logic [31:0] d = wdata;
    int seq [3] = '{3, 2, 0};
    if (rd_en && i >= 20 && i <= 22) m_stat[i-20] = 1'b0;
    m_stat = m_stat | src_evt;
    if (wr_en) begin
      if (i >= 4 && i <= 11) m_bank[i-4] = d;
      case (i)
        1:  m_dram = d;
        2:  m_ref = d;
        12: m_fb = d;
        13: m_row = d & ~32'd7;
        14: m_c1 = d;
        15: m_c2 = d;
        16: m_sense = d[2:0];
        19: m_mask = d[2:0];
        23: m_bus = d[2:0];
        17: begin
          m_half = vram_small && m_c1[1] && (d == 6);
          if (d == 7 && m_on) begin m_on = 0; m_step = 0; end
          else if (d == seq[m_step]) begin
            m_step++;
            if (m_step >= 3) begin
              if (m_c1[0]) begin m_on = 1; m_blank = 0; end
              else m_blank = 1;
              m_step = 0;
            end
          end else m_step = 0;
        end
        default: ;
      endcase
    end
  endtask

  task automatic fail_line(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_fail++;
    $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst_n) model_reset();
    else if (!done) begin
      logic [31:0] erd;
      model_step();
      erd = fmt(mval(int'(slot_addr)), int'(byte_lane), int'(rd_size));
      n_chk++;
      if (rdata !== erd) fail_line(tag_of(int'(slot_addr)), "rdata", rdata, erd);
      if (video_on !== m_on) fail_line("R4/R6", "video_on", 32'(video_on), 32'(m_on));
      if (video_blank !== m_blank) fail_line("R5", "video_blank", 32'(video_blank), 32'(m_blank));
      if (half_access !== m_half) fail_line("R7", "half_access", 32'(half_access), 32'(m_half));
      if (irq !== |(m_stat & m_mask)) fail_line("R11", "irq", 32'(irq), 32'(|(m_stat & m_mask)));
      if (fb_offset !== m_fb[21:0]) fail_line("R9", "fb_offset", 32'(fb_offset), 32'(m_fb[21:0]));
      if (row_pitch !== m_row) fail_line("R9", "row_pitch", row_pitch, m_row);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) fail_line(req, "directed", act, exp);
  endtask

  task automatic wr(int i, logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1; slot_addr = 8'(i); wdata = d;
    @(negedge clk); #1;
    wr_en = 0; wdata = 0;
  endtask

  task automatic rd(int i, int lane, int sz, logic [2:0] evt, output logic [31:0] v);
    @(negedge clk); #1;
    rd_en = 1; slot_addr = 8'(i); byte_lane = 2'(lane); rd_size = 3'(sz); src_evt = evt;
    #2 v = rdata;
    @(negedge clk); #1;
    rd_en = 0; rd_size = 0; byte_lane = 0; src_evt = 0;
  endtask

  task automatic pulse(logic [2:0] evt);
    @(negedge clk); #1; src_evt = evt;
    @(negedge clk); #1; src_evt = 0;
  endtask

  task automatic unlock();
    wr(17, 3); wr(17, 2); wr(17, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", 32'(video_on | video_blank | half_access | irq), 0);
    rd(0, 0, 4, 0, v);  chk("R1", v, CPU_ID_EXP);
    rd(16, 0, 4, 0, v); chk("R1", v, 32'd7);
    rd(7, 0, 4, 0, v);  chk("R1", v, 0);

    // R2: slot decode
    wr(9, 32'hCAFE_0005);
    rd(9, 0, 4, 0, v);  chk("R2", v, 32'hCAFE_0005);
    rd(4, 0, 4, 0, v);  chk("R2", v, 0);
    wr(1, 32'h0101_A5A5); wr(2, 32'h0000_0444); wr(15, 32'hDEAD_BEEF);
    rd(1, 0, 4, 0, v);  chk("R2", v, 32'h0101_A5A5);

    // R3 + R9: lanes on the frame buffer base
    wr(12, 32'h1122_3344);
    chk("R9", 32'(fb_offset), 32'h0022_3344);
    rd(12, 0, 1, 0, v); chk("R3", v, 32'h11);
    rd(12, 1, 1, 0, v); chk("R3", v, 32'h22);
    rd(12, 2, 2, 0, v); chk("R3", v, 32'h3344);
    rd(12, 3, 2, 0, v); chk("R3", v, 32'h4411);
    rd(12, 1, 4, 0, v); chk("R3", v, 32'h2233_4411);
    wr(13, 32'hFFFF_FFFF);
    chk("R9", row_pitch, 32'hFFFF_FFF8);

    // R8
    wr(16, 32'h0000_00F5);
    rd(16, 0, 4, 0, v); chk("R8", v, 32'd2);
    rd(16, 3, 1, 0, v); chk("R8", v, 32'd2);

    // R10
    wr(3, 32'hFFFF_FFFF);
    rd(3, 0, 4, 0, v);  chk("R10", v, 0);
    wr(23, 32'h1234_5675);
    rd(23, 0, 4, 0, v); chk("R10", v, 32'd5);

    // R4 / R6
    wr(14, 32'd1);
    wr(17, 3); wr(17, 2);
    chk("R4", 32'(video_on), 0);
    wr(17, 0);
    chk("R4", 32'(video_on), 1);
    chk("R4", 32'(video_blank), 0);
    wr(17, 7);
    chk("R6", 32'(video_on), 0);
    wr(17, 3); wr(17, 5); wr(17, 2); wr(17, 0);
    chk("R6", 32'(video_on), 0);
    wr(17, 3); wr(17, 7); wr(17, 2); wr(17, 0);
    chk("R6", 32'(video_on), 0);
    wr(17, 3); wr(17, 3); wr(17, 2); wr(17, 0);
    chk("R6", 32'(video_on), 0);
    unlock();
    chk("R6", 32'(video_on), 1);
    wr(17, 7);

    // R5
    wr(14, 32'd0);
    unlock();
    chk("R5", 32'(video_blank), 1);
    chk("R5", 32'(video_on), 0);
    wr(14, 32'd1);
    unlock();
    chk("R5", 32'(video_blank), 0);
    chk("R4", 32'(video_on), 1);

    // R7
    vram_small = 1;
    wr(14, 32'd3);
    wr(17, 6);  chk("R7", 32'(half_access), 1);
    wr(2, 32'h55);  chk("R7", 32'(half_access), 1);
    wr(17, 4);  chk("R7", 32'(half_access), 0);
    wr(14, 32'd1);
    wr(17, 6);  chk("R7", 32'(half_access), 0);
    vram_small = 0;
    wr(14, 32'd3);
    wr(17, 6);  chk("R7", 32'(half_access), 0);
    chk("R6", 32'(video_on), 1);

    // R11 / R12
    wr(19, 32'b101);
    pulse(3'b010);
    chk("R11", 32'(irq), 0);
    pulse(3'b100);
    chk("R11", 32'(irq), 1);
    rd(18, 0, 4, 0, v); chk("R11", v, 32'd6);
    rd(22, 0, 4, 0, v); chk("R12", v, 0);
    chk("R12", 32'(irq), 0);
    rd(18, 0, 4, 0, v); chk("R12", v, 32'd2);
    rd(21, 0, 4, 0, v);
    rd(18, 0, 4, 0, v); chk("R12", v, 0);
    rd(20, 0, 4, 3'b001, v); chk("R12", v, 0);
    chk("R12", 32'(irq), 1);
    rd(18, 0, 4, 0, v); chk("R12", v, 32'd1);
    rd(20, 0, 4, 0, v);
    chk("R12", 32'(irq), 0);

    // R13
    wr(40, 32'hFFFF_FFFF);
    rd(40, 0, 4, 0, v);  chk("R13", v, 0);
    wr(255, 32'd7);
    chk("R13", 32'(video_on), 1);
    rd(255, 0, 4, 0, v); chk("R13", v, 0);
    rd(17, 0, 4, 0, v);  chk("R13", v, 0);
    rd(12, 0, 4, 0, v);  chk("R13", v, 32'h1122_3344);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule